// File: doc/BRIEF.md
# Baseband Clock Divider Bank

This block turns one 26 MHz reference into the set of slower clocks a cellular baseband needs. It passes the reference through unchanged for the control processor. It makes a 13 MHz clock for the radio interface and a slow sleep clock of about 135.4 kHz. It makes a SIM card clock with three modes: full rate, half rate and stopped. It also makes a 512 kHz serial main clock with an 8 kHz frame sync, which the audio codec link and the accessory data link share. Every derived clock is a square wave registered in the reference domain, so the whole bank runs on one clock and one synchronous reset.

The 512 kHz rate is not an integer fraction of 26 MHz. A phase accumulator therefore chooses each toggle point, and the average rate comes out exact over every frame. A change of SIM clock mode is held back until the SIM clock is about to enter its low phase. No shortened pulse can reach the card. When the idle input is high, all derived clocks and the DSP oscillator enable are held low. When idle is released, every divider starts again from phase zero.

Top module: `bbclk_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every derived clock output, `frm_sync_o` and `dsp_osc_en_o` are low after that edge.
- R2: `mcu_clk_o` follows the reference clock. Outside idle, `rfi_clk_o` toggles on every reference edge, and it first goes high on the first edge after reset or idle is released.
- R3: `sleep_clk_o` is high for 96 reference cycles and low for 96, a period of 192. It first goes high on the 96th edge after a restart.
- R4: `ser_clk_o` comes from an accumulator that adds 1024 per edge modulo 26000 and toggles on each wrap. Every high or low run lasts 25 or 26 cycles, and the first rise comes on the 26th edge after a restart.
- R5: `frm_sync_o` rises together with a rising edge of `ser_clk_o` and stays high for exactly one `ser_clk_o` period (50 or 51 cycles). Successive sync rises are exactly 3250 reference cycles apart, with 64 `ser_clk_o` rising edges in that span.
- R6: `sim_mode_i` encoding: 2'b00 gives 4 high and 4 low cycles (divide by 8), 2'b01 gives 8 and 8 (divide by 16), and 2'b10 or 2'b11 holds `sim_clk_o` low. After a restart in full mode, the first rise comes on the 5th edge.
- R7: A new SIM mode takes effect only when the SIM clock falls, or while it is stopped. A high phase already in progress finishes at the old length, and the following low phase uses the new mode.
- R8: While `idle_i` is high, all derived clocks, `frm_sync_o` and `dsp_osc_en_o` go low at the next edge and stay low. `mcu_clk_o` keeps running.
- R9: After `idle_i` falls, every divider restarts from phase zero. The first rises come on edges 1 (`rfi_clk_o`), 5 (`sim_clk_o` in full mode), 26 (`ser_clk_o`) and 96 (`sleep_clk_o`).
- R10: `dsp_osc_en_o` is a registered copy of `dsp_osc_req_i` gated by the inverse of `idle_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 26 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Stops and zeroes all derived clocks |
| sim_mode_i | input | 2 | SIM clock mode: 00 full, 01 half, 1x stopped |
| dsp_osc_req_i | input | 1 | Request to run the DSP oscillator |
| mcu_clk_o | output | 1 | Reference passed through for the processor |
| rfi_clk_o | output | 1 | 13 MHz radio interface clock |
| sleep_clk_o | output | 1 | Sleep clock, reference divided by 192 |
| sim_clk_o | output | 1 | SIM card clock |
| ser_clk_o | output | 1 | 512 kHz serial main clock |
| frm_sync_o | output | 1 | 8 kHz frame sync, one serial period wide |
| dsp_osc_en_o | output | 1 | DSP oscillator enable |

## Verification
The hardest situation to create from the ports is a SIM mode change that arrives in the middle of a high phase. The bench waits at the falling clock edge until it first sees `sim_clk_o` high, then changes the mode right away. It then measures the current high run, the next low run and the next high run, which separates the old length from the new one. The frame sync interval needs a full 3250-cycle frame. The bench aligns to one sync rise, counts reference cycles and serial clock rises up to the next one, and so checks exact frequency rather than a rate averaged over an unknown start phase.

// File: rtl/bbclk_pkg.sv
package bbclk_pkg;

  typedef enum logic [1:0] {
    SIM_FULL = 2'b00,
    SIM_SLOW = 2'b01,
    SIM_STOP = 2'b10
  } sim_mode_e;

  // Maps the raw two-bit mode input onto the internal mode; bit 1 set means stopped.
  function automatic sim_mode_e sim_decode(input logic [1:0] raw);
    if (raw[1])      return SIM_STOP;
    else if (raw[0]) return SIM_SLOW;
    else             return SIM_FULL;
  endfunction

endpackage

// File: rtl/bbclk_toggle_div.sv
module bbclk_toggle_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic clk_o
);
  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (cnt == W'(HALF - 1)) begin
      cnt   <= '0;
      clk_o <= ~clk_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bbclk_frac_div.sv
module bbclk_frac_div #(
  parameter int REF_KHZ = 26000,
  parameter int OUT_KHZ = 512,
  parameter int FRAME   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic clk_o,
  output logic sync_o
);
  // Two toggles per output period, so the accumulator step is twice the output rate.
  localparam int INC = 2 * OUT_KHZ;
  localparam int MOD = REF_KHZ;
  localparam int AW  = $clog2(MOD + INC);
  localparam int FW  = (FRAME > 1) ? $clog2(FRAME) : 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;
  logic          wrap;
  logic [FW-1:0] per;

  always_comb begin
    sum  = acc + AW'(INC);
    wrap = (sum >= AW'(MOD));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc    <= '0;
      clk_o  <= 1'b0;
      per    <= '0;
      sync_o <= 1'b0;
    end else if (wrap) begin
      acc   <= sum - AW'(MOD);
      clk_o <= ~clk_o;
      if (!clk_o) begin
        // rising toggle: advance the period count inside the frame
        sync_o <= (per == FW'(FRAME - 1));
        per    <= (per == FW'(FRAME - 1)) ? '0 : per + 1'b1;
      end
    end else begin
      acc <= sum;
    end
  end
endmodule

// File: rtl/bbclk_sim_div.sv
module bbclk_sim_div
  import bbclk_pkg::*;
#(
  parameter int FULL_HALF = 4,
  parameter int SLOW_HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode_i,
  output logic       clk_o
);
  localparam int MAXH = (SLOW_HALF > FULL_HALF) ? SLOW_HALF : FULL_HALF;
  localparam int W    = (MAXH > 1) ? $clog2(MAXH) : 1;

  sim_mode_e     cur;
  logic [W-1:0]  cnt;
  logic [W-1:0]  last;

  always_comb begin
    last = (cur == SIM_SLOW) ? W'(SLOW_HALF - 1) : W'(FULL_HALF - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      clk_o <= 1'b0;
      cur   <= SIM_STOP;
    end else if (cur == SIM_STOP) begin
      cnt   <= '0;
      clk_o <= 1'b0;
      cur   <= sim_decode(mode_i);
    end else if (cnt == last) begin
      cnt   <= '0;
      clk_o <= ~clk_o;
      // mode is only reloaded as the clock falls into its low phase
      if (clk_o) cur <= sim_decode(mode_i);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bbclk_gen.sv
module bbclk_gen #(
  parameter int REF_KHZ       = 26000,
  parameter int SER_KHZ       = 512,
  parameter int FRAME_LEN     = 64,
  parameter int SLEEP_HALF    = 96,
  parameter int SIM_FULL_HALF = 4,
  parameter int SIM_SLOW_HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_i,
  input  logic [1:0] sim_mode_i,
  input  logic       dsp_osc_req_i,
  output logic       mcu_clk_o,
  output logic       rfi_clk_o,
  output logic       sleep_clk_o,
  output logic       sim_clk_o,
  output logic       ser_clk_o,
  output logic       frm_sync_o,
  output logic       dsp_osc_en_o
);
  localparam int NDIV = 2;
  localparam int DIV_HALF [NDIV] = '{1, SLEEP_HALF};

  logic            run;
  logic [NDIV-1:0] div_q;

  assign run       = ~idle_i;
  assign mcu_clk_o = clk;

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    bbclk_toggle_div #(.HALF(DIV_HALF[g])) u_div (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .clk_o (div_q[g])
    );
  end

  assign rfi_clk_o   = div_q[0];
  assign sleep_clk_o = div_q[1];

  bbclk_sim_div #(
    .FULL_HALF (SIM_FULL_HALF),
    .SLOW_HALF (SIM_SLOW_HALF)
  ) u_sim (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .mode_i (sim_mode_i),
    .clk_o  (sim_clk_o)
  );

  bbclk_frac_div #(
    .REF_KHZ (REF_KHZ),
    .OUT_KHZ (SER_KHZ),
    .FRAME   (FRAME_LEN)
  ) u_ser (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .clk_o  (ser_clk_o),
    .sync_o (frm_sync_o)
  );

  always_ff @(posedge clk) begin
    if (rst) dsp_osc_en_o <= 1'b0;
    else     dsp_osc_en_o <= dsp_osc_req_i & run;
  end
endmodule

// File: rtl/bbclk_gen_chk.sv
module bbclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic idle_i,
  input logic dsp_osc_req_i,
  input logic rfi_clk_o,
  input logic sleep_clk_o,
  input logic sim_clk_o,
  input logic ser_clk_o,
  input logic frm_sync_o,
  input logic dsp_osc_en_o
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !(rfi_clk_o || sleep_clk_o || sim_clk_o || ser_clk_o || frm_sync_o || dsp_osc_en_o));

  // R2
  rfi_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle_i && rfi_clk_o) |=> !rfi_clk_o);

  // R5
  sync_align_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_sync_o) |-> $rose(ser_clk_o));

  // R7
  sim_no_runt_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sim_clk_o) && !idle_i) |=> sim_clk_o);

  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    idle_i |=> !(rfi_clk_o || sleep_clk_o || sim_clk_o || ser_clk_o || frm_sync_o || dsp_osc_en_o));

  // R10
  dsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_osc_en_o |-> $past(dsp_osc_req_i && !idle_i));
endmodule

bind bbclk_gen bbclk_gen_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .idle_i        (idle_i),
  .dsp_osc_req_i (dsp_osc_req_i),
  .rfi_clk_o     (rfi_clk_o),
  .sleep_clk_o   (sleep_clk_o),
  .sim_clk_o     (sim_clk_o),
  .ser_clk_o     (ser_clk_o),
  .frm_sync_o    (frm_sync_o),
  .dsp_osc_en_o  (dsp_osc_en_o)
);

// File: tb/bbclk_gen_test.sv
module bbclk_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idle_i = 1'b0;
  logic [1:0] sim_mode_i = 2'b00;
  logic       dsp_osc_req_i = 1'b0;
  logic       mcu_clk_o, rfi_clk_o, sleep_clk_o, sim_clk_o, ser_clk_o, frm_sync_o, dsp_osc_en_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bbclk_gen uut (
    .clk           (clk),
    .rst           (rst),
    .idle_i        (idle_i),
    .sim_mode_i    (sim_mode_i),
    .dsp_osc_req_i (dsp_osc_req_i),
    .mcu_clk_o     (mcu_clk_o),
    .rfi_clk_o     (rfi_clk_o),
    .sleep_clk_o   (sleep_clk_o),
    .sim_clk_o     (sim_clk_o),
    .ser_clk_o     (ser_clk_o),
    .frm_sync_o    (frm_sync_o),
    .dsp_osc_en_o  (dsp_osc_en_o)
  );

  // SIM mode table: {mode[1:0], expected half period (0 = held low)}
  localparam logic [5:0] SIM_VEC [5] = '{
    {2'b00, 4'd4}, {2'b01, 4'd8}, {2'b10, 4'd0}, {2'b00, 4'd4}, {2'b11, 4'd0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return rfi_clk_o;
      1: return sleep_clk_o;
      2: return sim_clk_o;
      3: return ser_clk_o;
      default: return frm_sync_o;
    endcase
  endfunction

  function automatic int any_out();
    return int'(rfi_clk_o | sleep_clk_o | sim_clk_o | ser_clk_o | frm_sync_o | dsp_osc_en_o);
  endfunction

  task automatic run_len(input int sel, output int n);
    logic v;
    v = pick(sel);
    n = 0;
    while (pick(sel) == v && n < 5000) begin
      n++;
      tick();
    end
  endtask

  task automatic wait_rise(input int sel);
    int lim;
    lim = 0;
    while (pick(sel) && lim < 5000) begin lim++; tick(); end
    while (!pick(sel) && lim < 10000) begin lim++; tick(); end
  endtask

  // Called right after a restart was driven; records the tick of each first rise.
  task automatic first_rises(input string req);
    int fr [4];
    for (int s = 0; s < 4; s++) fr[s] = 0;
    for (int t = 1; t <= 100; t++) begin
      tick();
      for (int s = 0; s < 4; s++) if (fr[s] == 0 && pick(s)) fr[s] = t;
    end
    chk({req, " R2 rfi first rise"}, fr[0], 1);
    chk({req, " R3 sleep first rise"}, fr[1], 96);
    chk({req, " R6 sim first rise"}, fr[2], 5);
    chk({req, " R4 ser first rise"}, fr[3], 26);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, n2, rises, ones;
    logic ps, pq;

    // R1: reset state
    repeat (5) tick();
    chk("R1 outputs low in reset", any_out(), 0);
    rst = 1'b0;
    first_rises("R1 after reset");

    // R2: reference passthrough and 13 MHz toggling
    @(posedge clk); #5;
    chk("R2 mcu_clk high phase", int'(mcu_clk_o), 1);
    tick();
    chk("R2 mcu_clk low phase", int'(mcu_clk_o), 0);
    ones = 0;
    pq = rfi_clk_o;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (rfi_clk_o == pq) ones++;
      pq = rfi_clk_o;
    end
    chk("R2 rfi toggles every edge, repeats seen", ones, 0);

    // R3: sleep clock runs
    wait_rise(1);
    run_len(1, n);  chk("R3 sleep high run", n, 96);
    run_len(1, n);  chk("R3 sleep low run", n, 96);

    // R4: serial clock runs
    wait_rise(3);
    run_len(3, n);  chk_rng("R4 ser high run", n, 25, 26);
    run_len(3, n);  chk_rng("R4 ser low run", n, 25, 26);

    // R5: frame sync width, alignment and spacing
    wait_rise(4);
    chk("R5 ser high at sync rise", int'(ser_clk_o), 1);
    n = 0; rises = 0; n2 = 0;
    ps = ser_clk_o; pq = frm_sync_o;
    while (n < 5000) begin
      tick();
      n++;
      if (frm_sync_o && n2 == n - 1) n2 = n;
      if (ser_clk_o && !ps) rises++;
      ps = ser_clk_o;
      if (frm_sync_o && !pq) break;
      pq = frm_sync_o;
    end
    chk_rng("R5 sync high length", n2 + 1, 50, 51);
    chk("R5 sync spacing cycles", n, 3250);
    chk("R5 ser rises per frame", rises, 64);

    // R6: SIM mode table
    for (int i = 0; i < 5; i++) begin
      sim_mode_i = SIM_VEC[i][5:4];
      repeat (40) tick();
      if (SIM_VEC[i][3:0] == 4'd0) begin
        ones = 0;
        for (int t = 0; t < 64; t++) begin tick(); if (sim_clk_o) ones++; end
        chk("R6 sim held low when stopped", ones, 0);
      end else begin
        wait_rise(2);
        run_len(2, n); chk("R6 sim high run", n, int'(SIM_VEC[i][3:0]));
        run_len(2, n); chk("R6 sim low run", n, int'(SIM_VEC[i][3:0]));
      end
    end

    // R7: mode change during a high phase
    sim_mode_i = 2'b00;
    repeat (40) tick();
    wait_rise(2);
    sim_mode_i = 2'b01;
    run_len(2, n); chk("R7 old high phase kept", n, 4);
    run_len(2, n); chk("R7 new low phase", n, 8);
    run_len(2, n); chk("R7 new high phase", n, 8);
    wait_rise(2);
    sim_mode_i = 2'b10;
    run_len(2, n); chk("R7 high completes before stop", n, 8);
    ones = 0;
    for (int t = 0; t < 40; t++) begin tick(); if (sim_clk_o) ones++; end
    chk("R7 stopped after fall", ones, 0);

    // R10: DSP oscillator enable
    sim_mode_i = 2'b00;
    dsp_osc_req_i = 1'b1;
    tick();
    chk("R10 dsp enable follows request", int'(dsp_osc_en_o), 1);
    dsp_osc_req_i = 1'b0;
    tick();
    chk("R10 dsp enable drops", int'(dsp_osc_en_o), 0);

    // R8: idle gating
    dsp_osc_req_i = 1'b1;
    repeat (3) tick();
    idle_i = 1'b1;
    tick();
    chk("R8 outputs low one edge into idle", any_out(), 0);
    ones = 0;
    for (int t = 0; t < 300; t++) begin tick(); ones += any_out(); end
    chk("R8 outputs stay low in idle", ones, 0);
    @(posedge clk); #5;
    chk("R8 mcu_clk runs in idle", int'(mcu_clk_o), 1);
    tick();

    // R9: restart from phase zero after idle
    idle_i = 1'b0;
    first_rises("R9 after idle");
    chk("R9 dsp enable back after idle", int'(dsp_osc_en_o), 1);

    // R1: reset in mid-run
    rst = 1'b1;
    tick();
    chk("R1 mid-run reset clears outputs", any_out(), 0);
    rst = 1'b0;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule